// File: doc/BRIEF.md
# Fetch-Counting Windowed Deadman Timer

This block is a safety timer that guards the processor's software against a hang or a corrupted control flow. It counts the processor's instruction-fetch strobes, not clock cycles, so it stands still while the core sleeps. If software does not service it before the count reaches a fixed period, it pulses a reset request to the system reset controller and records that the timer caused the reset.

Servicing takes two ordered writes on a simple register bus. First software writes an arming key. Then it writes a clearing key, and the block takes the second key only while a clear window near the end of the period is open. A wrong key, a clear write without the arming step, or a clear outside the window counts as misuse. The block sets a status flag for the kind of misuse and requests a reset at once. After any reset request the timer freezes until the system reset arrives. The reset-cause flag has its own power-on reset, so it survives the system reset and software can read and clear it afterwards.

Top module: `fetch_deadman`

## Requirements
- R1: While enabled and not frozen, the count at offset 0x40 goes up by one on each clock edge where `fetch_strobe` is high and `sleep` is low. It does not move while `sleep` is high or the strobe is low, and it never goes above PERIOD.
- R2: Bit 15 of the control register at offset 0x00 enables the timer. While it is 0, fetches leave the count unchanged, key writes have no effect on the status register (offset 0x30 reads 0), and `reset_req` stays low.
- R3: Status bit 0 (window open) is 1 exactly while PERIOD-WINDOW <= count < PERIOD.
- R4: A write to offset 0x10 with 0x40 in bits 15:8 arms the clear. A later write to offset 0x20 with 0x08 in bits 7:0, made while the window is open, sets the count to 0 and disarms. No flag is set and no reset is requested. A further clear then needs a new arming write.
- R5: A write to offset 0x10 whose bits 15:8 are not 0x40 sets status bit 7. On the same clock edge it drives `reset_req` high.
- R6: A write to offset 0x20 that is not armed, or has bits 7:0 other than 0x08, or comes while the window is closed, sets status bit 6. On the same clock edge it drives `reset_req` high.
- R7: When the count has reached PERIOD, the next clock edge sets status bit 5 and drives `reset_req` high for exactly one cycle.
- R8: After a reset request the timer is frozen until `rst_n` is asserted. The count holds and writes to offsets 0x00, 0x10 and 0x20 have no effect.
- R9: `reset_cause` (also bit 5 at offset 0x50) is set only by a timeout. It is kept through `rst_n` and is cleared by `por_n` or by writing 1 to bit 5 at offset 0x50.
- R10: Offset 0x60 reads PERIOD and offset 0x70 reads WINDOW.
- R11: After reset the control, status and count registers read 0 and `reset_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears the reset-cause flag |
| rst_n | input | 1 | System reset, active low, clears everything else |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| fetch_strobe | input | 1 | One instruction fetch this cycle |
| sleep | input | 1 | Processor sleeping, counting held |
| reset_req | output | 1 | Single-cycle system reset request |
| reset_cause | output | 1 | Sticky flag: last reset came from a timeout |

## Verification
The bench builds the block with PERIOD=40 and WINDOW=10. With these values the window opens at count 30, so the timeout, the window edges and every misuse case can be reached in a few dozen fetches. Each kind of misuse runs in its own reset episode, because any reset request freezes the timer. One episode asserts only the system reset, which shows that the cause flag outlives it.

// File: rtl/fetch_deadman.sv
module fetch_deadman #(
  parameter int PERIOD = 1000,
  parameter int WINDOW = 100,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  output logic [DW-1:0] bus_rdata,
  input  logic          fetch_strobe,
  input  logic          sleep,
  output logic          reset_req,
  output logic          reset_cause
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD);
  localparam logic [CW-1:0] OPEN_AT = CW'(PERIOD - WINDOW);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] A_ARM  = AW'(8'h10);
  localparam logic [AW-1:0] A_CLR  = AW'(8'h20);
  localparam logic [AW-1:0] A_STAT = AW'(8'h30);
  localparam logic [AW-1:0] A_CNT  = AW'(8'h40);
  localparam logic [AW-1:0] A_CAUS = AW'(8'h50);
  localparam logic [AW-1:0] A_PER  = AW'(8'h60);
  localparam logic [AW-1:0] A_WIN  = AW'(8'h70);

  logic          en, armed, frozen, ev_flag, err_arm, err_clr;
  logic [CW-1:0] cnt;

  wire live    = en & ~frozen;
  wire at_end  = (cnt == LAST);
  wire win     = (cnt >= OPEN_AT) & ~at_end;
  wire wr_arm  = live & bus_we & (bus_addr == A_ARM);
  wire wr_clr  = live & bus_we & (bus_addr == A_CLR);
  wire arm_ok  = bus_wdata[15:8] == 8'h40;
  wire clr_ok  = armed & (bus_wdata[7:0] == 8'h08) & win;
  wire bad_arm = wr_arm & ~arm_ok;
  wire bad_clr = wr_clr & ~clr_ok;
  wire good    = wr_clr & clr_ok;
  wire timeout = live & at_end;
  wire fire    = timeout | bad_arm | bad_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      armed     <= 1'b0;
      frozen    <= 1'b0;
      ev_flag   <= 1'b0;
      err_arm   <= 1'b0;
      err_clr   <= 1'b0;
      reset_req <= 1'b0;
      cnt       <= '0;
    end else begin
      if (bus_we && bus_addr == A_CTRL && !frozen) en <= bus_wdata[15];
      if (good) cnt <= '0;
      else if (live && fetch_strobe && !sleep && !at_end) cnt <= cnt + 1'b1;
      if (wr_arm && arm_ok) armed <= 1'b1;
      else if (good) armed <= 1'b0;
      err_arm   <= err_arm | bad_arm;
      err_clr   <= err_clr | bad_clr;
      ev_flag   <= ev_flag | timeout;
      frozen    <= frozen | fire;
      reset_req <= fire;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) reset_cause <= 1'b0;
    else if (timeout) reset_cause <= 1'b1;
    else if (bus_we && bus_addr == A_CAUS && bus_wdata[5]) reset_cause <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[15] = en;
      A_STAT: begin
        bus_rdata[0] = win;
        bus_rdata[5] = ev_flag;
        bus_rdata[6] = err_clr;
        bus_rdata[7] = err_arm;
      end
      A_CNT:  bus_rdata = DW'(cnt);
      A_CAUS: bus_rdata[5] = reset_cause;
      A_PER:  bus_rdata = DW'(PERIOD);
      A_WIN:  bus_rdata = DW'(WINDOW);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fetch_deadman_chk.sv
module fetch_deadman_chk #(
  parameter int PERIOD = 1000,
  parameter int CW = 10,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_we,
  input logic          fetch_strobe,
  input logic          sleep,
  input logic          reset_req,
  input logic          reset_cause,
  input logic          en,
  input logic          frozen,
  input logic          err_arm,
  input logic          err_clr,
  input logic [CW-1:0] cnt
);
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  p_sleep_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !bus_we) |=> $stable(cnt));
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(PERIOD));
  p_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !reset_req);
  p_frozen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> ($stable(cnt) && $stable(en)));
  p_arm_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_arm |=> err_arm);
  p_clr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> err_clr);
  p_cause_keep_r9: assert property (@(posedge clk) disable iff (!por_n)
    (reset_cause && !(bus_we && bus_addr == AW'(8'h50) && bus_wdata[5])) |=> reset_cause);
endmodule

bind fetch_deadman fetch_deadman_chk #(.PERIOD(PERIOD), .CW(CW), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .fetch_strobe(fetch_strobe), .sleep(sleep), .reset_req(reset_req),
  .reset_cause(reset_cause), .en(en), .frozen(frozen), .err_arm(err_arm),
  .err_clr(err_clr), .cnt(cnt)
);

// File: tb/fetch_deadman_tb_top.sv
module fetch_deadman_tb_top;
  localparam int PERIOD = 40;
  localparam int WINDOW = 10;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, fetch_strobe = 1'b0, sleep = 1'b0;
  logic [31:0] bus_rdata;
  logic        reset_req, reset_cause;

  int checks = 0, errors = 0, exp_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fetch_deadman #(.PERIOD(PERIOD), .WINDOW(WINDOW)) dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .fetch_strobe(fetch_strobe), .sleep(sleep),
    .reset_req(reset_req), .reset_cause(reset_cause)
  );

  function automatic int next_cnt(int c, bit on, bit slp);
    return (on && !slp && c < PERIOD) ? c + 1 : c;
  endfunction

  function automatic int exp_win(int c);
    return (c >= PERIOD - WINDOW && c < PERIOD) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic fetch(int n, bit slp, bit on);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fetch_strobe = 1'b1; sleep = slp;
      @(posedge clk); #1;
      fetch_strobe = 1'b0; sleep = 1'b0;
      exp_cnt = next_cnt(exp_cnt, on, slp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic sys_reset(bit power);
    @(negedge clk);
    rst_n = 1'b0;
    if (power) por_n = 1'b0;
    idle(2);
    @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    exp_cnt = 0;
    idle(1);
  endtask

  task automatic stat(string req, int exp);
    int v;
    rd(8'h30, v);
    check(req, v & 32'hE1, exp);
  endtask

  initial begin
    int v;
    void'($urandom(1234));
    sys_reset(1);
    rd(8'h00, v); check("R11 ctrl", v, 0);
    rd(8'h40, v); check("R11 count", v, 0);
    stat("R11 status", 0);
    check("R11 reset_req", reset_req, 0);
    rd(8'h60, v); check("R10 period", v, PERIOD);
    rd(8'h70, v); check("R10 window", v, WINDOW);

    fetch(5, 0, 0);
    rd(8'h40, v); check("R2 disabled count", v, 0);
    wr(8'h10, 32'h1200);
    stat("R2 disabled key ignored", 0);
    check("R2 no request", reset_req, 0);

    wr(8'h00, 32'h8000);
    rd(8'h00, v); check("R2 enable bit", v, 32'h8000);
    fetch(5, 1, 1);
    rd(8'h40, v); check("R1 sleep hold", v, 0);
    fetch(7, 0, 1);
    rd(8'h40, v); check("R1 count", v, 7);
    for (int i = 0; i < 12; i++) begin
      int n;
      bit s;
      n = int'($urandom_range(0, 1));
      s = 1'($urandom_range(0, 1));
      fetch(n, s, 1);
      idle(int'($urandom_range(0, 2)));
      rd(8'h40, v); check("R1 random count", v, exp_cnt);
    end
    fetch(PERIOD - WINDOW - 1 - exp_cnt, 0, 1);
    rd(8'h40, v); check("R3 pre-window count", v, PERIOD - WINDOW - 1);
    stat("R3 window closed", exp_win(exp_cnt));
    fetch(1, 0, 1);
    stat("R3 window open", 1);
    wr(8'h10, 32'h4000);
    wr(8'h20, 32'h08);
    exp_cnt = 0;
    rd(8'h40, v); check("R4 cleared count", v, 0);
    stat("R4 no flags", 0);
    check("R4 no request", reset_req, 0);
    fetch(PERIOD - 2, 0, 1);
    stat("R3 window before end", 1);
    wr(8'h20, 32'h08);
    check("R4 rearm needed request", reset_req, 1);
    stat("R4 rearm needed flag", 32'h41);

    sys_reset(1);
    wr(8'h00, 32'h8000);
    fetch(PERIOD, 0, 1);
    stat("R3 window at end", 0);
    check("R7 not yet", reset_req, 0);
    idle(1);
    check("R7 request", reset_req, 1);
    stat("R7 event flag", 32'h20);
    check("R9 cause set", reset_cause, 1);
    idle(1);
    check("R7 single pulse", reset_req, 0);
    fetch(3, 0, 0);
    rd(8'h40, v); check("R8 frozen count", v, PERIOD);
    wr(8'h00, 32'h0);
    rd(8'h00, v); check("R8 frozen ctrl", v, 32'h8000);
    sys_reset(0);
    check("R9 cause kept", reset_cause, 1);
    rd(8'h50, v); check("R9 cause read", v, 32'h20);
    stat("R11 status after sys reset", 0);
    wr(8'h50, 32'h20);
    check("R9 cause cleared", reset_cause, 0);

    wr(8'h00, 32'h8000);
    wr(8'h10, 32'h1200);
    check("R5 request", reset_req, 1);
    stat("R5 flag", 32'h80);
    check("R9 no cause on key error", reset_cause, 0);

    sys_reset(1);
    wr(8'h00, 32'h8000);
    wr(8'h10, 32'h4000);
    fetch(5, 0, 1);
    wr(8'h20, 32'h08);
    check("R6 outside window request", reset_req, 1);
    stat("R6 outside window flag", 32'h40);

    sys_reset(1);
    wr(8'h00, 32'h8000);
    fetch(PERIOD - WINDOW + 2, 0, 1);
    wr(8'h20, 32'h08);
    check("R6 unarmed request", reset_req, 1);
    stat("R6 unarmed flag", 32'h41);

    sys_reset(1);
    wr(8'h00, 32'h8000);
    fetch(PERIOD - WINDOW + 2, 0, 1);
    wr(8'h10, 32'h4000);
    wr(8'h20, 32'h09);
    check("R6 wrong key request", reset_req, 1);
    stat("R6 wrong key flag", 32'h41);
    rd(8'h40, v); check("R8 count kept", v, PERIOD - WINDOW + 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule